// File: doc/BRIEF.md
# Periodic Interval Counter Channel

This block is a single down-counting channel of an interval timer, together with the byte-wide write port that programs it. Software first writes a command byte on the command port. The command byte names the channel it is meant for, the byte order, the counting mode and the number base. Two writes on the data port then supply a 16-bit divisor, low byte first. After the divisor is complete, the channel counts input-rate ticks down to one, reloads itself, and starts again. The result is a periodic output pulse at the tick rate divided by the divisor. A larger divisor therefore gives a slower output.

The input-rate tick comes from a prescaler of the system clock, so the whole block runs in one clock domain. Up to three channels can share one command port. Each instance answers only to its own channel number. Only the periodic (rate-generator) mode with binary counting and two-byte loading is built. The output line is meant to drive a periodic interrupt request.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is high and the channel does not count. Data-port writes made before any accepted command byte have no effect, so the output stays high.
- R2: A command byte is accepted only when all of these hold: bits 7:6 equal the parameter CHANNEL_ID, bits 5:4 equal 2'b11 (low byte, then high byte), bits 2:1 equal 2'b10 (periodic mode, which covers bits 3:1 = 010 and 110), and bit 0 is 0 (binary). Any other command byte is ignored, and a running count continues unchanged.
- R3: An accepted command byte stops counting at once and forces the output high. The next data byte is then taken as the low byte.
- R4: The second data byte after an accepted command byte completes the divisor as {second, first}. The count loads the divisor on the first tick after that write, and the first low pulse follows N-1 ticks later.
- R5: With a divisor N from 2 to 65535, the output is low for exactly one tick period out of every N ticks. It goes low when the count reaches one.
- R6: After the low pulse the count reloads the same divisor without any further write, so the output period stays N ticks indefinitely.
- R7: A divisor of 0 acts as 65536 ticks.
- R8: A tick occurs once every PRESCALE system clocks, so the low pulse lasts PRESCALE system clocks.
- R9: Writing a new low/high pair without a new command byte replaces the divisor, and counting restarts from the new value on the next tick.
- R10: A lone low-byte write, with no high byte after it, leaves the running count and the output period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| ctrlWe | input | 1 | One-cycle strobe for a command byte write |
| ctrlByte | input | 8 | Command byte |
| dataWe | input | 1 | One-cycle strobe for a data byte write to this channel |
| dataByte | input | 8 | Divisor byte |
| timerOut | output | 1 | Periodic output, low for one tick at terminal count |

## Verification
The assertions assume that each write strobe lasts one system clock. They also assume that reset is released synchronously. They further assume that a command byte and a data byte do not arrive on the same edge; if they do, the command byte wins and the data byte is dropped. The pulse-hold and reload properties are only meaningful for divisors of 2 or more, because a divisor of 1 keeps the output low. The stimulus therefore uses only single-cycle strobes driven between clock edges, never issues both strobes together, and loads divisors of 0, 3, 10 and 300.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int COUNT_W = 16;
  localparam int BYTE_W  = 8;

  // strobes from the write front end to the counting datapath
  typedef struct packed {
    logic               stop;      // accepted command byte: halt and rearm
    logic               loadFull;  // high byte written: divisor complete
    logic [COUNT_W-1:0] divisor;   // assembled divisor, valid with loadFull
  } pitStrobe_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE == 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_count
      logic [PW-1:0] phase;
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

      always_ff @(posedge clk) begin
        if (!rstN)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
      end

      assign tick = (phase == LAST);

      // R8: ticks never fall on consecutive system clocks when dividing
      a_r8_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CHANNEL_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [BYTE_W-1:0] ctrlByte,
  input  logic              dataWe,
  input  logic [BYTE_W-1:0] dataByte,
  output pitStrobe_t        stb
);
  logic [1:0] selField;
  logic [1:0] accField;
  logic [2:0] modeField;
  logic       bcdBit;
  logic       wordOk;

  logic              cfgValid;
  logic              expectHigh;
  logic [BYTE_W-1:0] lowByte;

  assign selField  = ctrlByte[7:6];
  assign accField  = ctrlByte[5:4];
  assign modeField = ctrlByte[3:1];
  assign bcdBit    = ctrlByte[0];

  // only periodic mode, two-byte load, binary, own channel
  assign wordOk = ctrlWe
               && (selField == 2'(CHANNEL_ID))
               && (accField == 2'b11)
               && (modeField[1:0] == 2'b10)
               && !bcdBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgValid   <= 1'b0;
      expectHigh <= 1'b0;
      lowByte    <= '0;
    end else if (wordOk) begin
      cfgValid   <= 1'b1;
      expectHigh <= 1'b0;
    end else if (dataWe && cfgValid) begin
      if (!expectHigh) begin
        lowByte    <= dataByte;
        expectHigh <= 1'b1;
      end else begin
        expectHigh <= 1'b0;
      end
    end
  end

  assign stb.stop     = wordOk;
  assign stb.loadFull = !wordOk && dataWe && cfgValid && expectHigh;
  assign stb.divisor  = {dataByte, lowByte};

  // R2: a rejected command byte leaves the byte sequencing untouched
  a_r2_reject_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && !wordOk && !dataWe) |=> ($stable(cfgValid) && $stable(expectHigh)));

  // R1: without an accepted command byte no divisor is ever completed
  a_r1_no_load_unarmed: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> !stb.loadFull);
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  pitStrobe_t stb,
  output logic       timerOut
);
  logic [COUNT_W-1:0] count;
  logic [COUNT_W-1:0] divisorReg;
  logic               pending;
  logic               running;
  logic               atOne;

  assign atOne = (count == COUNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      divisorReg <= '0;
      pending    <= 1'b0;
      running    <= 1'b0;
    end else if (stb.stop) begin
      running <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (tick && pending) begin
        count   <= divisorReg;
        running <= 1'b1;
        pending <= 1'b0;
      end else if (tick && running) begin
        // zero wraps to all ones, giving a full 65536-tick period
        count <= atOne ? divisorReg : count - 1'b1;
      end
      if (stb.loadFull) begin
        divisorReg <= stb.divisor;
        pending    <= 1'b1;
      end
    end
  end

  assign timerOut = !(running && atOne);

  // R3: an accepted command byte halts counting and releases the output
  a_r3_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stb.stop |=> (timerOut && !running));

  // R4: the first tick after completion loads the divisor
  a_r4_start_load: assert property (@(posedge clk) disable iff (!rstN)
    (tick && pending && !stb.stop) |=> (running && count == $past(divisorReg)));

  // R5: between terminal counts the value steps down by one per tick
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (tick && running && !pending && !stb.stop && !atOne) |=> (count == $past(count) - 1'b1));

  // R6: terminal count reloads the held divisor
  a_r6_reload: assert property (@(posedge clk) disable iff (!rstN)
    (tick && running && !pending && !stb.stop && atOne) |=> (count == $past(divisorReg)));

  // R8: a low output is held until a tick arrives
  a_r8_low_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!timerOut && !tick && !stb.stop && !stb.loadFull) |=> !timerOut);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHANNEL_ID = 0,
  parameter int PRESCALE   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlByte,
  input  logic       dataWe,
  input  logic [7:0] dataByte,
  output logic       timerOut
);
  logic       tick;
  pitStrobe_t stb;

  pit_prescaler #(.PRESCALE(PRESCALE)) prescaler_i (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  pit_ctrl #(.CHANNEL_ID(CHANNEL_ID)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .ctrlByte (ctrlByte),
    .dataWe   (dataWe),
    .dataByte (dataByte),
    .stb      (stb)
  );

  pit_datapath datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .stb      (stb),
    .timerOut (timerOut)
  );
endmodule

// File: tb/pit_channel_tb_top.sv
module pit_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRESC      = 2;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [7:0] ctrlByte = 8'h00;
  logic       dataWe = 1'b0;
  logic [7:0] dataByte = 8'h00;
  logic       timerOut;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  pit_channel #(.CHANNEL_ID(0), .PRESCALE(PRESC)) dut_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlByte(ctrlByte),
    .dataWe(dataWe), .dataByte(dataByte), .timerOut(timerOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference: tick phase and ticks elapsed since the last load
  int mPre, mLow, mDiv, mK, mN;
  bit mCfg, mHigh, mPend, mRun;

  always @(posedge clk) begin
    bit tk;
    bit ok;
    if (!rstN) begin
      mPre = 0; mLow = 0; mDiv = 0; mK = 0; mN = 1;
      mCfg = 0; mHigh = 0; mPend = 0; mRun = 0;
    end else begin
      tk = (mPre == PRESC - 1);
      mPre = tk ? 0 : mPre + 1;
      ok = ctrlWe && ctrlByte[7:6] == 2'd0 && ctrlByte[5:4] == 2'b11
           && ctrlByte[2:1] == 2'b10 && !ctrlByte[0];
      if (ok) begin
        mRun = 0; mPend = 0; mCfg = 1; mHigh = 0;
      end else begin
        if (tk) begin
          if (mPend) begin
            mRun = 1; mK = 0; mPend = 0;
            mN = (mDiv == 0) ? 65536 : mDiv;
          end else if (mRun) begin
            mK = (mK + 1) % mN;
          end
        end
        if (dataWe && mCfg) begin
          if (!mHigh) begin mLow = dataByte; mHigh = 1; end
          else begin mDiv = dataByte * 256 + mLow; mPend = 1; mHigh = 0; end
        end
      end
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    bit expOut;
    if (rstN && !done) begin
      expOut = !(mRun && (mK == mN - 1));
      checks++;
      if (timerOut !== expOut) begin
        errors++;
        $display("FAIL R5 model compare cycle %0d: actual=%0b expected=%0b", cyc, timerOut, expOut);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [7:0] b);
    @(negedge clk); ctrlWe = 1'b1; ctrlByte = b;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic writeData(input logic [7:0] b);
    @(negedge clk); dataWe = 1'b1; dataByte = b;
    @(negedge clk); dataWe = 1'b0;
  endtask

  task automatic waitEdge(input bit wantFall, output int t);
    bit prev;
    prev = timerOut;
    forever begin
      @(negedge clk);
      if (wantFall && prev && !timerOut) break;
      if (!wantFall && !prev && timerOut) break;
      prev = timerOut;
    end
    t = cyc;
  endtask

  task automatic measurePeriod(input string tag, input int expCycles);
    int t0, t1, t2;
    waitEdge(1, t0);
    waitEdge(0, t1);
    waitEdge(1, t2);
    check(t1 - t0 == PRESC, "R8 low pulse width", t1 - t0, PRESC);
    check(t2 - t0 == expCycles, tag, t2 - t0, expCycles);
  endtask

  task automatic holdHigh(input int n, input string tag);
    int lows;
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!timerOut) lows++;
    end
    check(lows == 0, tag, lows, 0);
  endtask

  task automatic firstFall(input int n, input string tag);
    int tw, tf;
    tw = cyc;
    waitEdge(1, tf);
    check((tf - tw) >= (n - 1) * PRESC + 1 && (tf - tw) <= n * PRESC, tag, tf - tw, n * PRESC);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(timerOut == 1'b1, "R1 reset output", timerOut, 1);

    // R1: data writes before any command byte
    writeData(8'h05);
    writeData(8'h00);
    holdHigh(40, "R1 unarmed data ignored");

    // R4, R5, R6: divisor 10, low byte first
    writeCtrl(8'h34);
    writeData(8'h0A);
    writeData(8'h00);
    firstFall(10, "R4 first pulse after load");
    measurePeriod("R5 period divisor 10", 10 * PRESC);
    measurePeriod("R6 reload keeps period", 10 * PRESC);

    // R2: foreign channel, BCD, single-byte access, other mode: all ignored
    writeCtrl(8'h74);
    measurePeriod("R2 other channel ignored", 10 * PRESC);
    writeCtrl(8'h35);
    measurePeriod("R2 bcd word ignored", 10 * PRESC);
    writeCtrl(8'h24);
    writeCtrl(8'h30);
    measurePeriod("R2 access and mode ignored", 10 * PRESC);

    // R10: a lone low byte changes nothing
    writeData(8'h03);
    measurePeriod("R10 lone low byte", 10 * PRESC);
    // R9: completing it with a high byte reloads divisor 3
    writeData(8'h00);
    measurePeriod("R9 rewrite divisor 3", 3 * PRESC);

    // R3: accepted command byte halts
    writeCtrl(8'h34);
    holdHigh(60, "R3 halted after command");
    writeData(8'h2C);
    writeData(8'h01);
    firstFall(300, "R4 first pulse divisor 300");
    measurePeriod("R5 period divisor 300", 300 * PRESC);

    // R7: mode bits 110 and divisor 0
    writeCtrl(8'h3C);
    writeData(8'h00);
    writeData(8'h00);
    firstFall(65536, "R7 divisor zero is 65536");

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule